// File: doc/BRIEF.md
# Radio Packet Receive Handler

This block sits behind a demodulator and turns a serial bit stream into packet bytes. Bits arrive one at a time, each qualified by a bit-valid strobe. The block hunts for a run of alternating preamble bits followed by a programmed sync word. Once the sync word is seen it locks byte alignment and frames one packet. The packet length either comes from a length byte carried in the packet or from a fixed configured count.

During reception the block can drop a packet whose address byte does not match the configured address. It can also check a CRC-16 carried in two trailing bytes, and it can append two status bytes that hold the received signal strength, the link quality and the CRC verdict. Accepted bytes leave through a one-byte-per-cycle FIFO write interface. A one-cycle pulse marks sync detection and another marks the end of the packet. A held flag reports the CRC result of the last finished packet.

Configuration and the RSSI/link-quality inputs are sampled live and must stay stable while a packet is being received.

Top module: `pkt_rx_handler`

## Requirements
- R1: Sync comparison is armed only after at least 8 consecutive alternating bits have been received while hunting. With `long_sync_i`=1 the last 32 received bits are compared with `sync_word_i`; otherwise the last 16 bits are compared with `sync_word_i[15:0]`. The first bit received is bit 31 (or 15). On a match `sync_pulse_o` is high for one cycle, in the cycle after the bit-valid cycle of the final sync bit.
- R2: After sync, bytes are assembled MSB first. With `var_len_i`=1 the first byte is a length N, and exactly N further data bytes follow. The length byte and the N data bytes are written to the FIFO in arrival order.
- R3: With `var_len_i`=0, exactly `fix_len_i` data bytes (1 to 255) are received and written.
- R4: With `addr_chk_i`=1 the first data byte (after the length byte in variable mode) is compared with `addr_i`. On a mismatch no byte of the packet is written, no end pulse occurs, and hunting restarts.
- R5: With `crc_en_i`=1, two bytes follow the data: the CRC high byte first, then the low byte. These bytes are not written. The CRC is CRC-16 with polynomial 0x8005 and initial value 0xFFFF, processed MSB first over the length, address and data bytes, with no final inversion. `crc_ok_o` goes to 1 at packet end when the CRC matches. It is 0 on a mismatch and when CRC checking is off, is cleared at sync, and holds between packets.
- R6: With `status_en_i`=1, two bytes are written after the data: first `rssi_i`, then {CRC-OK flag in bit 7, `lqi_i` in bits 6:0}.
- R7: In variable mode a length byte of 0 ends the packet with no writes and no end pulse, and hunting restarts.
- R8: `eop_pulse_o` is high for one cycle per completed packet. It coincides with the packet's last FIFO write, or it comes alone one cycle after the final CRC byte when that byte causes no write.
- R9: FIFO writes go out one byte per cycle, in packet order, and never in the same cycle as `sync_pulse_o`.
- R10: After reset, `wr_en_o`, `sync_pulse_o`, `eop_pulse_o` and `crc_ok_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Demodulated data bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` for one cycle |
| sync_word_i | input | 32 | Sync pattern |
| long_sync_i | input | 1 | 1: 32-bit sync, 0: 16-bit sync |
| var_len_i | input | 1 | 1: length byte in packet, 0: fixed length |
| fix_len_i | input | 8 | Data byte count in fixed mode |
| addr_chk_i | input | 1 | Enable address filter |
| addr_i | input | 8 | Accepted address |
| crc_en_i | input | 1 | Enable CRC check |
| status_en_i | input | 1 | Enable status byte append |
| rssi_i | input | 8 | Signal strength for status byte |
| lqi_i | input | 7 | Link quality for status byte |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | FIFO write byte |
| sync_pulse_o | output | 1 | Sync detected |
| eop_pulse_o | output | 1 | Packet finished |
| crc_ok_o | output | 1 | CRC verdict of the last packet |

## Verification
Packets are sent in both length modes, with 16- and 32-bit sync words, and with random gaps between bit strobes. This separates framing errors from alignment errors. Preambles of exactly 7 and exactly 8 alternating bits show where arming starts. Good and corrupted CRCs, matching and mismatching addresses, and a zero length byte each give a different expected write stream and end-pulse count. Random mixes of all enables with random payloads and status inputs then check that every combination gives the byte order and CRC flag computed by the bench's own packet model.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        PH_LEN    = 2'd0,
        PH_DATA   = 2'd1,
        PH_CRC_HI = 2'd2,
        PH_CRC_LO = 2'd3
    } rx_phase_e;

    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // One byte through the CRC register, most significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] b);
        logic [15:0] r;
        r = cur ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/prx_sync_det.sv
module prx_sync_det #(
    parameter int PRE_MIN  = 8,
    parameter int SYNC_MAX = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hunt_i,
    input  logic                bit_i,
    input  logic                bit_vld_i,
    input  logic [SYNC_MAX-1:0] sync_word_i,
    input  logic                long_sync_i,
    output logic                hit_o
);
    localparam int RW   = $clog2(PRE_MIN + 1);
    localparam int HALF = SYNC_MAX / 2;

    typedef struct packed {
        logic [SYNC_MAX-1:0] sh;
        logic                prev;
        logic [RW-1:0]       run;
        logic                armed;
    } det_s;

    det_s q, d;
    logic [SYNC_MAX-1:0] sh_next;
    logic                match;

    always_comb begin
        d       = q;
        hit_o   = 1'b0;
        sh_next = {q.sh[SYNC_MAX-2:0], bit_i};
        match   = long_sync_i ? (sh_next == sync_word_i)
                              : (sh_next[HALF-1:0] == sync_word_i[HALF-1:0]);
        if (!hunt_i) begin
            d.run   = '0;
            d.armed = 1'b0;
        end else if (bit_vld_i) begin
            d.sh   = sh_next;
            d.prev = bit_i;
            if (q.run != '0 && bit_i != q.prev) begin
                if (q.run != RW'(PRE_MIN)) begin
                    d.run = q.run + RW'(1);
                end
            end else begin
                d.run = RW'(1);
            end
            if (d.run == RW'(PRE_MIN)) begin
                d.armed = 1'b1;
            end
            hit_o = q.armed & match;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/prx_byte_asm.sv
module prx_byte_asm #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          bit_i,
    input  logic          bit_vld_i,
    output logic          byte_vld_o,
    output logic [BW-1:0] byte_o
);
    localparam int CW = $clog2(BW);

    typedef struct packed {
        logic [BW-1:0] sh;
        logic [CW-1:0] cnt;
    } asm_s;

    asm_s q, d;

    always_comb begin
        d          = q;
        byte_o     = {q.sh[BW-2:0], bit_i};
        byte_vld_o = en_i & bit_vld_i & (q.cnt == CW'(BW - 1));
        if (!en_i) begin
            d.cnt = '0;
        end else if (bit_vld_i) begin
            d.sh  = byte_o;
            d.cnt = (q.cnt == CW'(BW - 1)) ? '0 : q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/prx_emit_q.sv
module prx_emit_q #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_i,
    input  logic [$clog2(DEPTH+1)-1:0] push_n_i,
    input  logic [DEPTH-1:0][W-1:0] push_data_i,
    input  logic                    eop_req_i,
    output logic                    wr_en_o,
    output logic [W-1:0]            wr_data_o,
    output logic                    eop_o
);
    localparam int NW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [NW-1:0]           cnt;
        logic                    eop_pend;
        logic                    wr;
        logic [W-1:0]            data;
        logic                    eop;
    } emq_s;

    emq_s q, d;

    always_comb begin
        d     = q;
        d.wr  = 1'b0;
        d.eop = 1'b0;
        if (q.cnt != '0) begin
            d.wr   = 1'b1;
            d.data = q.mem[0];
            for (int i = 0; i < DEPTH - 1; i++) begin
                d.mem[i] = q.mem[i+1];
            end
            d.cnt = q.cnt - NW'(1);
            if (q.cnt == NW'(1) && q.eop_pend) begin
                d.eop      = 1'b1;
                d.eop_pend = 1'b0;
            end
        end
        if (push_i) begin
            d.mem      = push_data_i;
            d.cnt      = push_n_i;
            d.eop_pend = eop_req_i;
            if (push_n_i == '0 && eop_req_i) begin
                d.eop      = 1'b1;
                d.eop_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en_o   = q.wr;
    assign wr_data_o = q.data;
    assign eop_o     = q.eop;

    // R9: a new packet burst only arrives once the previous one has drained
    a_r9_push_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (q.cnt == '0));

endmodule

// File: rtl/pkt_rx_handler.sv
module pkt_rx_handler
    import pkt_rx_pkg::*;
#(
    parameter int PRE_MIN  = 8,
    parameter int SYNC_MAX = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_i,
    input  logic                bit_vld_i,
    input  logic [SYNC_MAX-1:0] sync_word_i,
    input  logic                long_sync_i,
    input  logic                var_len_i,
    input  logic [7:0]          fix_len_i,
    input  logic                addr_chk_i,
    input  logic [7:0]          addr_i,
    input  logic                crc_en_i,
    input  logic                status_en_i,
    input  logic [7:0]          rssi_i,
    input  logic [6:0]          lqi_i,
    output logic                wr_en_o,
    output logic [7:0]          wr_data_o,
    output logic                sync_pulse_o,
    output logic                eop_pulse_o,
    output logic                crc_ok_o
);
    localparam int BW    = 8;
    localparam int QD    = 4;
    localparam int QNW   = $clog2(QD + 1);

    typedef struct packed {
        rx_state_e   st;
        rx_phase_e   ph;
        logic [7:0]  rem;
        logic        addr_next;
        logic [7:0]  held;
        logic [15:0] crc;
        logic [7:0]  crc_hi;
        logic        sync;
        logic        crc_ok;
    } ctl_s;

    ctl_s q, d;

    logic                 hit;
    logic                 byte_vld;
    logic [BW-1:0]        rx_byte;
    logic                 push;
    logic [QNW-1:0]       pn;
    logic [QD-1:0][BW-1:0] pd;
    logic                 eop_req;
    logic                 fin;
    logic                 fin_ok;
    logic                 keep;

    prx_sync_det #(.PRE_MIN(PRE_MIN), .SYNC_MAX(SYNC_MAX)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .hunt_i      (q.st == ST_HUNT),
        .bit_i       (bit_i),
        .bit_vld_i   (bit_vld_i),
        .sync_word_i (sync_word_i),
        .long_sync_i (long_sync_i),
        .hit_o       (hit)
    );

    prx_byte_asm #(.BW(BW)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (q.st == ST_RECV),
        .bit_i      (bit_i),
        .bit_vld_i  (bit_vld_i),
        .byte_vld_o (byte_vld),
        .byte_o     (rx_byte)
    );

    always_comb begin
        d       = q;
        d.sync  = 1'b0;
        pn      = '0;
        pd      = '0;
        eop_req = 1'b0;
        fin     = 1'b0;
        fin_ok  = 1'b0;
        keep    = 1'b1;
        if (q.st == ST_HUNT) begin
            if (hit) begin
                d.st        = ST_RECV;
                d.ph        = var_len_i ? PH_LEN : PH_DATA;
                d.rem       = fix_len_i;
                d.addr_next = addr_chk_i;
                d.crc       = CRC_SEED;
                d.sync      = 1'b1;
                d.crc_ok    = 1'b0;
            end
        end else if (byte_vld) begin
            case (q.ph)
                PH_LEN: begin
                    if (rx_byte == '0) begin
                        d.st = ST_HUNT;                 // R7: empty packet dropped
                    end else begin
                        d.rem  = rx_byte;
                        d.held = rx_byte;
                        d.crc  = crc16_step(q.crc, rx_byte);
                        d.ph   = PH_DATA;
                        if (!q.addr_next) begin
                            pd[pn[1:0]] = rx_byte;
                            pn          = pn + QNW'(1);
                        end
                    end
                end
                PH_DATA: begin
                    d.crc = crc16_step(q.crc, rx_byte);
                    d.rem = q.rem - 8'd1;
                    if (q.addr_next) begin
                        d.addr_next = 1'b0;
                        if (rx_byte != addr_i) begin
                            d.st = ST_HUNT;             // R4: foreign address
                            keep = 1'b0;
                        end else if (var_len_i) begin
                            pd[pn[1:0]] = q.held;       // release the held length byte
                            pn          = pn + QNW'(1);
                        end
                    end
                    if (keep) begin
                        pd[pn[1:0]] = rx_byte;
                        pn          = pn + QNW'(1);
                        if (q.rem == 8'd1) begin
                            if (crc_en_i) begin
                                d.ph = PH_CRC_HI;
                            end else begin
                                fin = 1'b1;
                            end
                        end
                    end
                end
                PH_CRC_HI: begin
                    d.crc_hi = rx_byte;
                    d.ph     = PH_CRC_LO;
                end
                default: begin
                    fin    = 1'b1;
                    fin_ok = (q.crc == {q.crc_hi, rx_byte});
                end
            endcase
            if (fin) begin
                d.st     = ST_HUNT;
                d.crc_ok = fin_ok;
                eop_req  = 1'b1;
                if (status_en_i) begin
                    pd[pn[1:0]] = rssi_i;
                    pn          = pn + QNW'(1);
                    pd[pn[1:0]] = {fin_ok, lqi_i};
                    pn          = pn + QNW'(1);
                end
            end
        end
        push = (pn != '0) | eop_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.crc <= CRC_SEED;
        end else begin
            q <= d;
        end
    end

    prx_emit_q #(.DEPTH(QD), .W(BW)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_n_i    (pn),
        .push_data_i (pd),
        .eop_req_i   (eop_req),
        .wr_en_o     (wr_en_o),
        .wr_data_o   (wr_data_o),
        .eop_o       (eop_pulse_o)
    );

    assign sync_pulse_o = q.sync;
    assign crc_ok_o     = q.crc_ok;

    // R1: a sync pulse only follows a cycle spent hunting
    a_r1_sync_from_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |-> ($past(q.st) == ST_HUNT));

    // R9: byte writes of one packet never overlap the next sync
    a_r9_no_wr_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |-> !wr_en_o);

    // R8: end pulse lasts a single cycle
    a_r8_eop_single: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse_o |=> !eop_pulse_o);

    // R5: the CRC verdict is cleared whenever a new packet starts
    a_r5_crc_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |-> !crc_ok_o);

endmodule

// File: tb/sim_pkt_rx_handler.sv
module sim_pkt_rx_handler;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic [31:0] sync_word_i = 32'h0000_D391;
    logic        long_sync_i = 1'b0;
    logic        var_len_i = 1'b1;
    logic [7:0]  fix_len_i = 8'd4;
    logic        addr_chk_i = 1'b0;
    logic [7:0]  addr_i = 8'h5C;
    logic        crc_en_i = 1'b0;
    logic        status_en_i = 1'b0;
    logic [7:0]  rssi_i = 8'h00;
    logic [6:0]  lqi_i = 7'h00;
    logic        wr_en_o;
    logic [7:0]  wr_data_o;
    logic        sync_pulse_o;
    logic        eop_pulse_o;
    logic        crc_ok_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pkt_rx_handler u0 (
        .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .sync_word_i(sync_word_i), .long_sync_i(long_sync_i), .var_len_i(var_len_i),
        .fix_len_i(fix_len_i), .addr_chk_i(addr_chk_i), .addr_i(addr_i),
        .crc_en_i(crc_en_i), .status_en_i(status_en_i), .rssi_i(rssi_i), .lqi_i(lqi_i),
        .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .sync_pulse_o(sync_pulse_o),
        .eop_pulse_o(eop_pulse_o), .crc_ok_o(crc_ok_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] cap[$];
    logic [7:0] air[$];
    logic [7:0] exp_q[$];
    int n_sync = 0;
    int n_eop  = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en_o) cap.push_back(wr_data_o);
            if (sync_pulse_o) n_sync++;
            if (eop_pulse_o) n_eop++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb = r[15] ^ b[k];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        int g = $urandom_range(0, 2);
        repeat (g) tick();
        bit_i     = b;
        bit_vld_i = 1'b1;
        tick();
        bit_vld_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) send_bit(b[k]);
    endtask

    task automatic send_sync();
        int nb = long_sync_i ? 32 : 16;
        for (int k = nb - 1; k >= 0; k--) send_bit(sync_word_i[k]);
    endtask

    task automatic clear_mon();
        cap.delete();
        n_sync = 0;
        n_eop  = 0;
    endtask

    task automatic cmp_bytes(input string req);
        int bad = -1;
        chk(req, "write count", cap.size(), exp_q.size());
        if (cap.size() == exp_q.size()) begin
            for (int k = 0; k < cap.size(); k++) begin
                if (bad < 0 && cap[k] != exp_q[k]) bad = k;
            end
            if (bad >= 0) begin
                $display("FAIL %s byte %0d: got %0d expected %0d", req, bad, cap[bad], exp_q[bad]);
            end
            chk(req, "first mismatching byte index", bad, -1);
        end
    endtask

    // Sends one framed packet and checks writes, pulses and CRC flag.
    task automatic run_pkt(input string req, input int len, input bit corrupt, input bit bad_addr);
        logic [15:0] c = 16'hFFFF;
        bit dropped;
        bit ok;
        air.delete();
        exp_q.delete();
        if (!var_len_i) fix_len_i = 8'(len);
        if (var_len_i) air.push_back(8'(len));
        for (int k = 0; k < len; k++) begin
            if (k == 0 && addr_chk_i) air.push_back(bad_addr ? ~addr_i : addr_i);
            else air.push_back(8'($urandom));
        end
        foreach (air[k]) c = ref_crc(c, air[k]);
        dropped = (var_len_i && len == 0) || (addr_chk_i && bad_addr);
        ok      = crc_en_i && !corrupt;
        if (!dropped) begin
            foreach (air[k]) exp_q.push_back(air[k]);
            if (status_en_i) begin
                exp_q.push_back(rssi_i);
                exp_q.push_back({ok, lqi_i});
            end
        end
        if (crc_en_i && !(var_len_i && len == 0)) begin
            air.push_back(c[15:8] ^ (corrupt ? 8'h10 : 8'h00));
            air.push_back(c[7:0]);
        end
        clear_mon();
        repeat (4) send_byte(8'hAA);
        send_sync();
        foreach (air[k]) send_byte(air[k]);
        repeat (30) tick();
        chk("R1", "sync pulses", n_sync, 1);
        cmp_bytes(req);
        chk(dropped ? req : "R8", "end pulses", n_eop, dropped ? 0 : 1);
        chk("R5", "crc flag", int'(crc_ok_o), int'(!dropped && ok));
    endtask

    // Preamble of a given alternating length, then sync and a short packet.
    task automatic run_pre(input int alt_bits, input int exp_sync);
        var_len_i = 1'b1; addr_chk_i = 1'b0; crc_en_i = 1'b0; status_en_i = 1'b0;
        long_sync_i = 1'b0;
        clear_mon();
        send_bit(1'b1);
        for (int k = 0; k < alt_bits; k++) send_bit(k[0] ? 1'b0 : 1'b1);
        send_sync();
        send_byte(8'h02); send_byte(8'h00); send_byte(8'h00);
        repeat (30) tick();
        chk("R1", $sformatf("sync pulses after %0d preamble bits", alt_bits), n_sync, exp_sync);
        chk("R1", "writes after preamble test", cap.size(), exp_sync * 3);
    endtask

    initial begin
        void'($urandom(32'd7311));
        repeat (3) tick();
        chk("R10", "wr_en after reset", int'(wr_en_o), 0);
        chk("R10", "sync after reset", int'(sync_pulse_o), 0);
        chk("R10", "eop after reset", int'(eop_pulse_o), 0);
        chk("R10", "crc flag after reset", int'(crc_ok_o), 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // preamble boundary: the run starts at the second 1, so 7 vs 8 bits
        run_pre(7, 0);
        run_pre(8, 1);

        // R2 variable length, good CRC, status bytes
        var_len_i = 1'b1; addr_chk_i = 1'b0; crc_en_i = 1'b1; status_en_i = 1'b1;
        rssi_i = 8'hC4; lqi_i = 7'h35;
        run_pkt("R6", 5, 1'b0, 1'b0);
        chk("R6", "status crc bit on good crc", int'(cap.size() > 0 ? cap[cap.size()-1][7] : 1'b0), 1);
        // R5 corrupted CRC
        run_pkt("R5", 4, 1'b1, 1'b0);
        // R3 fixed length, no CRC, no status
        var_len_i = 1'b0; crc_en_i = 1'b0; status_en_i = 1'b0;
        run_pkt("R3", 5, 1'b0, 1'b0);
        // R4 address mismatch in both modes
        addr_chk_i = 1'b1; crc_en_i = 1'b1;
        run_pkt("R4", 3, 1'b0, 1'b1);
        var_len_i = 1'b1;
        run_pkt("R4", 3, 1'b0, 1'b1);
        // R4 match with only the address byte, status on: four writes
        crc_en_i = 1'b0; status_en_i = 1'b1;
        run_pkt("R4", 1, 1'b0, 1'b0);
        // R7 zero length
        addr_chk_i = 1'b0;
        run_pkt("R7", 0, 1'b0, 1'b0);
        // R1 32-bit sync
        long_sync_i = 1'b1; sync_word_i = 32'h9B6E_3C5A; crc_en_i = 1'b1;
        run_pkt("R2", 6, 1'b0, 1'b0);

        // R9 random mixes of every option
        for (int it = 0; it < 24; it++) begin
            var_len_i   = 1'($urandom);
            addr_chk_i  = 1'($urandom);
            crc_en_i    = 1'($urandom);
            status_en_i = 1'($urandom);
            long_sync_i = 1'($urandom);
            sync_word_i = long_sync_i ? 32'h9B6E_3C5A : 32'h0000_D391;
            addr_i      = 8'($urandom);
            rssi_i      = 8'($urandom);
            lqi_i       = 7'($urandom);
            run_pkt("R9", $urandom_range(1, 10), 1'($urandom), 1'b0);
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule